// File: doc/BRIEF.md
# Split DC-Link Capacitor Balance Vector Group Selector

This block decides, once per modulation sampling interval, which of two redundant inverter switching combinations a cascaded multilevel inverter should apply so that the two capacitors of a split DC link stay at equal voltage. It receives a signed, already digitised difference between the upper and lower capacitor voltages (upper minus lower). One redundant vector group charges the lower capacitor and the other charges the upper capacitor. The block emits a state code that joins the chosen group with the nominal sequence index supplied by the modulator.

Two comparators with hysteresis watch the difference. The inner comparator has a narrow band and, while power flows from the link into the motor, picks the group that pulls the difference back toward zero. When power flows back into the link, each group's effect on the capacitors reverses and the inner choice makes the imbalance grow. A wider outer comparator catches that growth. Once it fires, a registered regeneration flag inverts the mapping from inner decision to group until the difference settles back inside the inner band. Driving the enable input low forces the nominal combination and clears all comparator and flag state.

Top module: `capbal_selector`

## Requirements
- R1: After reset, `state_code` is all zeros: group field 2'b00 (nominal) and sequence field 0.
- R2: `state_code` is {group[1:0], seq}, where the group sits in the two top bits and the sequence index, captured on the same strobe, sits in the low SEQ_W bits. The group codes are 2'b00 nominal, 2'b01 charge-lower and 2'b10 charge-upper. Code 2'b11 never appears.
- R3: With the regeneration flag clear, a sampled difference strictly above `inner_thr` selects charge-lower (2'b01), and one strictly below `-inner_thr` selects charge-upper (2'b10).
- R4: A difference equal to plus or minus `inner_thr` does not fire an idle inner comparator, so the group stays nominal.
- R5: A fired comparator keeps its direction until the difference falls to the exit level `thr - margin` or below (for the positive side) or rises to its negative or above (for the negative side). It then returns to nominal. The exit level is clamped at 0 when `margin` exceeds `thr`.
- R6: A sampled difference strictly beyond plus or minus `outer_thr` sets the regeneration flag in the same update. While the flag is set, a positive inner decision selects 2'b10 and a negative one selects 2'b01.
- R7: The regeneration flag stays set after the outer comparator has released, as long as the inner comparator is still active. It clears on the update in which the inner comparator returns to nominal.
- R8: `state_code` and all decision state change only on a clock edge where `sample_valid` is high while `enable` is high. Otherwise the code holds for the whole interval.
- R9: While `enable` is low, each clock edge loads `state_code` with {2'b00, seq} and clears both comparators and the regeneration flag, so decisions after re-enable start from the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Balancing enable; low forces the nominal combination and clears state |
| sample_valid | input | 1 | One-cycle strobe marking a new sampling interval |
| diff | input | DIFF_W | Signed upper-minus-lower capacitor voltage difference |
| inner_thr | input | DIFF_W-1 | Inner band entry threshold (magnitude) |
| outer_thr | input | DIFF_W-1 | Outer band entry threshold (magnitude) |
| margin | input | DIFF_W-1 | Hysteresis margin subtracted from a threshold to form its exit level |
| seq | input | SEQ_W | Nominal sequence index from the modulator |
| state_code | output | SEQ_W+2 | Selected group (top two bits) joined with the captured sequence index |

## Verification
The bench builds the block with DIFF_W = 10 and SEQ_W = 3, an inner threshold of 40, an outer threshold of 100 and a margin of 10. With these settings the entry edges, the exit edges at 30 and 90, and the outer crossing can all be reached with small signed differences. The narrow sequence field lets every strobe carry a distinct index, so a stale capture shows up as a wrong low field. Later the margin is raised above the inner threshold to reach the clamped exit level at zero. Regeneration is driven from both polarities, and enable is dropped with both a fired comparator and a set flag, to show that no decision survives a disable.

// File: rtl/capbal_pkg.sv
package capbal_pkg;

    // Direction reported by one hysteresis comparator
    typedef enum logic [1:0] {
        CMP_IDLE = 2'b00,
        CMP_POS  = 2'b01,
        CMP_NEG  = 2'b10
    } cmp_e;

    // Redundant vector group carried in the top two bits of the state code
    typedef enum logic [1:0] {
        GRP_NOMINAL   = 2'b00,
        GRP_CHG_LOWER = 2'b01,
        GRP_CHG_UPPER = 2'b10
    } grp_e;

    localparam int GRP_W = 2;

endpackage

// File: rtl/capbal_hyst_cmp.sv
module capbal_hyst_cmp
    import capbal_pkg::*;
#(
    parameter int DIFF_W = 12
) (
    input  logic signed [DIFF_W-1:0] diff,
    input  logic        [DIFF_W-2:0] thr,
    input  logic        [DIFF_W-2:0] margin,
    input  cmp_e                     cur,
    output cmp_e                     nxt
);
    localparam int EXT_W = DIFF_W + 1;

    logic signed [EXT_W-1:0] d_ext;
    logic signed [EXT_W-1:0] entry_lvl;
    logic signed [EXT_W-1:0] exit_lvl;
    logic        [DIFF_W-2:0] exit_mag;

    always_comb begin
        d_ext     = {diff[DIFF_W-1], diff};
        exit_mag  = (margin > thr) ? '0 : (thr - margin);
        entry_lvl = $signed({2'b00, thr});
        exit_lvl  = $signed({2'b00, exit_mag});

        nxt = cur;
        if (d_ext > entry_lvl) begin
            nxt = CMP_POS;
        end else if (d_ext < -entry_lvl) begin
            nxt = CMP_NEG;
        end else if (cur == CMP_POS && d_ext <= exit_lvl) begin
            nxt = CMP_IDLE;
        end else if (cur == CMP_NEG && d_ext >= -exit_lvl) begin
            nxt = CMP_IDLE;
        end
    end

endmodule

// File: rtl/capbal_group_map.sv
module capbal_group_map
    import capbal_pkg::*;
(
    input  cmp_e dir,
    input  logic regen,
    output grp_e grp
);
    always_comb begin
        unique case (dir)
            CMP_POS: grp = regen ? GRP_CHG_UPPER : GRP_CHG_LOWER;
            CMP_NEG: grp = regen ? GRP_CHG_LOWER : GRP_CHG_UPPER;
            default: grp = GRP_NOMINAL;
        endcase
    end

endmodule

// File: rtl/capbal_selector.sv
module capbal_selector
    import capbal_pkg::*;
#(
    parameter int DIFF_W = 12,
    parameter int SEQ_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable,
    input  logic                      sample_valid,
    input  logic signed [DIFF_W-1:0]  diff,
    input  logic        [DIFF_W-2:0]  inner_thr,
    input  logic        [DIFF_W-2:0]  outer_thr,
    input  logic        [DIFF_W-2:0]  margin,
    input  logic        [SEQ_W-1:0]   seq,
    output logic        [SEQ_W+1:0]   state_code
);
    localparam int CODE_W  = SEQ_W + GRP_W;
    localparam int N_BANDS = 2;
    localparam int B_INNER = 0;
    localparam int B_OUTER = 1;

    typedef struct packed {
        cmp_e              inner;
        cmp_e              outer;
        logic              regen;
        logic [CODE_W-1:0] code;
    } sel_state_t;

    sel_state_t st_d, st_q;

    logic [DIFF_W-2:0] band_thr [N_BANDS];
    cmp_e              band_cur [N_BANDS];
    cmp_e              band_nxt [N_BANDS];
    logic              regen_nx;
    grp_e              grp_sel;

    assign band_thr[B_INNER] = inner_thr;
    assign band_thr[B_OUTER] = outer_thr;
    assign band_cur[B_INNER] = st_q.inner;
    assign band_cur[B_OUTER] = st_q.outer;

    for (genvar b = 0; b < N_BANDS; b++) begin : g_band
        capbal_hyst_cmp #(.DIFF_W(DIFF_W)) u_cmp (
            .diff   (diff),
            .thr    (band_thr[b]),
            .margin (margin),
            .cur    (band_cur[b]),
            .nxt    (band_nxt[b])
        );
    end

    // Outer firing sets the flag; inner returning idle clears it
    always_comb begin
        if (band_nxt[B_OUTER] != CMP_IDLE) begin
            regen_nx = 1'b1;
        end else if (band_nxt[B_INNER] == CMP_IDLE) begin
            regen_nx = 1'b0;
        end else begin
            regen_nx = st_q.regen;
        end
    end

    capbal_group_map u_map (
        .dir   (band_nxt[B_INNER]),
        .regen (regen_nx),
        .grp   (grp_sel)
    );

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.inner = CMP_IDLE;
            st_d.outer = CMP_IDLE;
            st_d.regen = 1'b0;
            st_d.code  = {GRP_NOMINAL, seq};
        end else if (sample_valid) begin
            st_d.inner = band_nxt[B_INNER];
            st_d.outer = band_nxt[B_OUTER];
            st_d.regen = regen_nx;
            st_d.code  = {grp_sel, seq};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{inner: CMP_IDLE, outer: CMP_IDLE, regen: 1'b0, code: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign state_code = st_q.code;

    // Observation points for the bound checker
    logic regen_q;
    cmp_e inner_q;
    assign regen_q = st_q.regen;
    assign inner_q = st_q.inner;

endmodule

// File: rtl/capbal_selector_chk.sv
module capbal_selector_chk
    import capbal_pkg::*;
#(
    parameter int SEQ_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             sample_valid,
    input logic [SEQ_W-1:0] seq,
    input logic [SEQ_W+1:0] state_code,
    input logic             regen_q,
    input cmp_e             inner_q
);
    logic [1:0] grp_f;
    assign grp_f = state_code[SEQ_W+1:SEQ_W];

    // R2: the unused group code never appears
    a_r2_group_legal: assert property (@(posedge clk) disable iff (!rst_n)
        grp_f != 2'b11);

    // R8: no strobe while enabled means the code is held
    a_r8_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !sample_valid) |=> $stable(state_code));

    // R8: the regeneration flag only rises on a strobe
    a_r8_regen_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(regen_q) |-> $past(sample_valid && enable));

    // R9: disabled edge loads the nominal group and the current sequence index
    a_r9_disable_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (grp_f == 2'b00 && state_code[SEQ_W-1:0] == $past(seq) && !regen_q));

    // R3: an idle inner comparator pairs with the nominal group, an active one never does
    a_r3_idle_is_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        (inner_q == CMP_IDLE) == (grp_f == 2'b00));

endmodule

bind capbal_selector capbal_selector_chk #(.SEQ_W(SEQ_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .sample_valid (sample_valid),
    .seq          (seq),
    .state_code   (state_code),
    .regen_q      (regen_q),
    .inner_q      (inner_q)
);

// File: tb/capbal_selector_bench.sv
module capbal_selector_bench;
    localparam int DIFF_W = 10;
    localparam int SEQ_W  = 3;
    localparam int CODE_W = SEQ_W + 2;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     enable = 1'b1;
    logic                     sample_valid = 1'b0;
    logic signed [DIFF_W-1:0] diff = '0;
    logic        [DIFF_W-2:0] inner_thr = 9'd40;
    logic        [DIFF_W-2:0] outer_thr = 9'd100;
    logic        [DIFF_W-2:0] margin = 9'd10;
    logic        [SEQ_W-1:0]  seq = '0;
    logic        [CODE_W-1:0] state_code;

    capbal_selector #(.DIFF_W(DIFF_W), .SEQ_W(SEQ_W)) u_capbal_selector (
        .clk, .rst_n, .enable, .sample_valid, .diff,
        .inner_thr, .outer_thr, .margin, .seq, .state_code
    );

    always #10 clk = ~clk;  // 50 MHz

    int tests_run = 0;
    int tests_failed = 0;
    logic expect_now = 1'b0;
    logic done = 1'b0;
    logic [CODE_W-1:0] exp_q[$];
    string tag_q[$];
    logic [CODE_W-1:0] last_exp = '0;

    localparam logic [1:0] NOM = 2'b00, LOW = 2'b01, UPP = 2'b10;

    task automatic check(input logic [CODE_W-1:0] act, input logic [CODE_W-1:0] exp, input string tag);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Driver: one strobed sample, expected code pushed to the scoreboard
    task automatic drive_sample(input int d, input int s, input logic [1:0] g, input string tag);
        logic [SEQ_W-1:0] sv;
        sv = s[SEQ_W-1:0];
        @(negedge clk);
        diff = d[DIFF_W-1:0];
        seq = sv;
        sample_valid = 1'b1;
        expect_now = 1'b1;
        exp_q.push_back({g, sv});
        tag_q.push_back(tag);
        last_exp = {g, sv};
        @(negedge clk);
        sample_valid = 1'b0;
        expect_now = 1'b0;
    endtask

    // Driver: one cycle with enable low, no strobe
    task automatic drive_disabled(input int d, input int s, input string tag);
        logic [SEQ_W-1:0] sv;
        sv = s[SEQ_W-1:0];
        @(negedge clk);
        diff = d[DIFF_W-1:0];
        seq = sv;
        enable = 1'b0;
        expect_now = 1'b1;
        exp_q.push_back({NOM, sv});
        tag_q.push_back(tag);
        last_exp = {NOM, sv};
        @(negedge clk);
        enable = 1'b1;
        expect_now = 1'b0;
    endtask

    // Monitor: compares the code a few ns after the updating edge
    initial begin
        forever begin
            @(posedge clk);
            if (expect_now) begin
                #5;
                check(state_code, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(state_code, '0, "R1 reset code");
        rst_n = 1'b1;
        @(negedge clk);
        check(state_code, '0, "R1 code after reset release");

        drive_sample(40, 1, NOM, "R4 diff equal to +inner_thr");
        drive_sample(-40, 2, NOM, "R4 diff equal to -inner_thr");
        drive_sample(41, 3, LOW, "R3 above inner band, R2 field layout");
        drive_sample(31, 4, LOW, "R5 held above exit level");
        drive_sample(30, 5, NOM, "R5 released at exit level");
        drive_sample(-41, 6, UPP, "R3 below inner band");
        drive_sample(-31, 7, UPP, "R5 negative held");
        drive_sample(-30, 0, NOM, "R5 negative released");

        // R8: big difference without a strobe must not move the code
        @(negedge clk);
        diff = 10'sd200;
        seq = 3'd5;
        repeat (3) @(negedge clk);
        check(state_code, last_exp, "R8 no strobe, code held");

        drive_sample(101, 6, UPP, "R6 outer fired positive, mapping inverted");
        drive_sample(85, 1, UPP, "R7 outer released, flag kept");
        drive_sample(-50, 2, LOW, "R7 flag kept across polarity change");
        drive_sample(0, 3, NOM, "R7 inner idle clears flag");
        drive_sample(50, 4, LOW, "R7 flag cleared, motoring mapping");
        drive_sample(-101, 5, LOW, "R6 outer fired negative, mapping inverted");

        // R9: disable with active comparators and flag, then re-enable inside the hold zone
        drive_sample(101, 1, UPP, "R6 regen before disable");
        drive_disabled(35, 7, "R9 disabled code nominal with seq");
        drive_sample(35, 2, NOM, "R9 state cleared by disable");
        drive_sample(45, 3, LOW, "R9 flag cleared by disable");
        drive_sample(0, 4, NOM, "R5 back to idle");

        // R5: margin larger than threshold clamps exit level to 0
        @(negedge clk);
        margin = 9'd50;
        drive_sample(41, 5, LOW, "R5 clamp: entry");
        drive_sample(1, 6, LOW, "R5 clamp: held at +1");
        drive_sample(0, 7, NOM, "R5 clamp: released at 0");

        repeat (2) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                tests_run++;
                tests_failed++;
                $display("FAIL watchdog (R1..all pending): actual hung, expected done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule